// File: doc/BRIEF.md
# Display Serial Command Engine with Response Capture

This block turns a stream of byte requests into serial traffic for a display controller that uses a write/read serial link plus a separate pin marking command versus parameter bytes. Each request holds one byte, a flag telling whether the byte is a command, and a count of response bytes to collect. An accepted byte goes out one bit per system clock, most significant bit first, while the select pin carries that byte's flag.

A transaction is a command byte followed by zero or more parameter bytes. The last byte of a transaction may ask for a nonzero number of response bytes. The engine then samples the controller-in line for that many bytes. Each byte is handed downstream as a one-cycle response pulse. Only after that does the engine take a new request. Chip select, clock division and initialization sequencing belong to the surrounding logic.

Top module: `disp_spi_cmd`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a transfer, leaves req_ready high and sclk_o, copi_o, rsp_valid and cmd_sel_o low.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is then low for the eight cycles that follow, one for each bit.
- R3: During the eight transmit cycles, sclk_o is high and copi_o shows bit 7 of req_data first and bit 0 last, one bit per cycle. copi_o is low outside transmit cycles.
- R4: cmd_sel_o takes the accepted req_is_cmd value from the first transmit cycle and holds it until the next request is accepted.
- R5: With req_rsp_len equal to zero, req_ready is high and sclk_o is low in the cycle right after the eighth transmit cycle.
- R6: With req_rsp_len equal to N greater than zero, exactly N bytes are received before a new request is taken. Throughout this phase, req_ready and sclk_o stay low.
- R7: cipo_i is sampled on eight consecutive clock edges, most significant bit first. The first sample is taken at the end of the cycle that follows the last transmit cycle. Those eight bits appear on rsp_data with rsp_valid high for exactly one cycle, in the cycle after the eighth sample.
- R8: The rsp_valid cycle is the single gap cycle between consecutive response bytes. After the last response byte's rsp_valid cycle, req_ready is high.
- R9: A req_valid held high while the engine is busy (transmitting, receiving or presenting) has no effect on the pins or on the response stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request byte offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_data | input | DATA_W | Byte to transmit |
| req_is_cmd | input | 1 | 1 = command byte, 0 = parameter byte |
| req_rsp_len | input | LEN_W | Number of response bytes to collect after this byte |
| rsp_valid | output | 1 | One-cycle pulse marking a received byte |
| rsp_data | output | DATA_W | Last received byte |
| sclk_o | output | 1 | Serial clock, high during transmit bit cycles |
| copi_o | output | 1 | Serial data toward the display controller |
| cmd_sel_o | output | 1 | Command/parameter select toward the display controller |
| cipo_i | input | 1 | Serial data from the display controller |

## Verification
Two things can fall in the same cycle: a new request offered by upstream, and the engine's closing work, which is the last response pulse or the eighth transmit bit. The driver keeps req_valid high with the next byte as soon as the previous byte is taken. The next transaction is therefore always pending while a read is still being collected or presented. A cycle-accurate behavioural model decides on each edge whether a request is taken, using its own idea of readiness. Every output is compared against it in every cycle, so an early or doubled acceptance shows up as a mismatch on req_ready, sclk_o or copi_o.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_SHOW
  } eng_state_t;

endpackage

// File: rtl/disp_spi_ctrl.sv
module disp_spi_ctrl
  import disp_spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_rsp_len,
  output logic             ready_q,
  output logic             sclk_q,
  output logic             rsp_valid_q,
  output logic             tx_load,
  output logic             tx_shift,
  output logic             rx_sample,
  output logic             rx_last
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_t       st;
  logic [CNT_W-1:0] bit_cnt;
  logic [LEN_W-1:0] rem_cnt;

  assign tx_load   = req_valid && ready_q;
  assign tx_shift  = (st == ST_TX);
  assign rx_sample = (st == ST_RX);
  assign rx_last   = rx_sample && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      rem_cnt     <= '0;
      ready_q     <= 1'b1;
      sclk_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          rsp_valid_q <= 1'b0;
          if (tx_load) begin
            st      <= ST_TX;
            ready_q <= 1'b0;
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
            rem_cnt <= req_rsp_len;
          end
        end
        ST_TX: begin
          if (bit_cnt == LAST_BIT) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            if (rem_cnt == '0) begin
              st      <= ST_IDLE;
              ready_q <= 1'b1;
            end else begin
              st <= ST_RX;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_RX: begin
          if (bit_cnt == LAST_BIT) begin
            st          <= ST_SHOW;
            rsp_valid_q <= 1'b1;
            rem_cnt     <= rem_cnt - 1'b1;
            bit_cnt     <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_SHOW: begin
          rsp_valid_q <= 1'b0;
          if (rem_cnt == '0) begin
            st      <= ST_IDLE;
            ready_q <= 1'b1;
          end else begin
            st <= ST_RX;
          end
        end
        default: begin
          st      <= ST_IDLE;
          ready_q <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/disp_spi_tx.sv
module disp_spi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  input  logic              is_cmd,
  output logic              copi_q,
  output logic              sel_q
);

  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      copi_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (load) begin
      sh     <= data << 1;
      copi_q <= data[DATA_W-1];
      sel_q  <= is_cmd;
    end else if (shift) begin
      sh     <= sh << 1;
      copi_q <= sh[DATA_W-1];
    end
  end

endmodule

// File: rtl/disp_spi_rx.sv
module disp_spi_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              last,
  input  logic              cipo,
  output logic [DATA_W-1:0] rsp_data_q
);

  logic [DATA_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      rsp_data_q <= '0;
    end else if (sample) begin
      sh <= {sh[DATA_W-3:0], cipo};
      if (last) rsp_data_q <= {sh, cipo};
    end
  end

endmodule

// File: rtl/disp_spi_cmd.sv
module disp_spi_cmd #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_is_cmd,
  input  logic [LEN_W-1:0]  req_rsp_len,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sclk_o,
  output logic              copi_o,
  output logic              cmd_sel_o,
  input  logic              cipo_i
);

  logic tx_load, tx_shift, rx_sample, rx_last;

  disp_spi_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_rsp_len (req_rsp_len),
    .ready_q     (req_ready),
    .sclk_q      (sclk_o),
    .rsp_valid_q (rsp_valid),
    .tx_load     (tx_load),
    .tx_shift    (tx_shift),
    .rx_sample   (rx_sample),
    .rx_last     (rx_last)
  );

  disp_spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load   (tx_load),
    .shift  (tx_shift),
    .data   (req_data),
    .is_cmd (req_is_cmd),
    .copi_q (copi_o),
    .sel_q  (cmd_sel_o)
  );

  disp_spi_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sample     (rx_sample),
    .last       (rx_last),
    .cipo       (cipo_i),
    .rsp_data_q (rsp_data)
  );

endmodule

// File: rtl/disp_spi_cmd_chk.sv
module disp_spi_cmd_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic sclk_o,
  input logic copi_o,
  input logic cmd_sel_o
);

  AST_TAKE_STARTS_TX: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (sclk_o && !req_ready)); // R2

  AST_BUSY_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    (sclk_o || rsp_valid) |-> !req_ready); // R6

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7

  AST_SEL_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(cmd_sel_o)); // R4

  AST_COPI_QUIET_OFF_TX: assert property (@(posedge clk) disable iff (rst)
    (!sclk_o && !$past(sclk_o)) |-> !copi_o); // R3

  AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid) |=> req_ready); // R9

endmodule

bind disp_spi_cmd disp_spi_cmd_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sclk_o    (sclk_o),
  .copi_o    (copi_o),
  .cmd_sel_o (cmd_sel_o)
);

// File: tb/test_disp_spi_cmd.sv
`timescale 1ns/1ps
module test_disp_spi_cmd;

  localparam int DW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [DW-1:0] req_data = '0;
  logic          req_is_cmd = 1'b0;
  logic [LW-1:0] req_rsp_len = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          sclk_o, copi_o, cmd_sel_o;
  logic          cipo_i = 1'b0;

  always #2 clk = ~clk;

  disp_spi_cmd #(.DATA_W(DW), .LEN_W(LW)) i_disp_spi_cmd (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_is_cmd(req_is_cmd), .req_rsp_len(req_rsp_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sclk_o(sclk_o),
    .copi_o(copi_o), .cmd_sel_o(cmd_sel_o), .cipo_i(cipo_i)
  );

  // model cycle kinds: 0 idle, 1 transmit bit, 2 receive sample, 3 present
  typedef struct packed {
    logic [1:0] kind;
    logic       bit_v;
  } slot_t;

  slot_t         plan[$];
  slot_t         cur;
  logic          m_sel;
  logic [DW-1:0] m_shift;
  int            n_cmp = 0;
  int            n_bad = 0;
  int            n_rsp = 0;
  bit            done = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk) begin
    if (rst) begin
      plan.delete();
      cur     = '0;
      m_sel   = 1'b0;
      m_shift = '0;
    end else begin
      if (cur.kind == 2'd2) m_shift = {m_shift[DW-2:0], cipo_i};
      if (cur.kind == 2'd0 && req_valid) begin
        m_sel = req_is_cmd;
        for (int i = DW - 1; i >= 0; i--) plan.push_back({2'd1, req_data[i]});
        for (int n = 0; n < int'(req_rsp_len); n++) begin
          for (int k = 0; k < DW; k++) plan.push_back({2'd2, 1'b0});
          plan.push_back({2'd3, 1'b0});
        end
      end
      if (plan.size() > 0) cur = plan.pop_front();
      else cur = '0;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      string rt;
      case (cur.kind)
        2'd0: rt = "R5";
        2'd1: rt = "R2";
        2'd2: rt = "R6";
        default: rt = "R8";
      endcase
      if (req_valid && cur.kind != 2'd0) rt = "R9";
      chk(rt, DW'(req_ready), DW'(cur.kind == 2'd0));
      chk((cur.kind == 2'd2) ? "R6" : "R3", DW'(sclk_o), DW'(cur.kind == 2'd1));
      chk("R3", DW'(copi_o), DW'((cur.kind == 2'd1) ? cur.bit_v : 1'b0));
      chk("R4", DW'(cmd_sel_o), DW'(m_sel));
      chk("R7", DW'(rsp_valid), DW'(cur.kind == 2'd3));
      if (cur.kind == 2'd3) begin
        chk("R7", rsp_data, m_shift);
        n_rsp++;
      end
    end
  end

  always @(negedge clk) cipo_i = 1'($urandom_range(0, 1));

  task automatic check_reset_state();
    chk("R1", DW'(req_ready), DW'(1));
    chk("R1", DW'(sclk_o), DW'(0));
    chk("R1", DW'(copi_o), DW'(0));
    chk("R1", DW'(rsp_valid), DW'(0));
    chk("R1", DW'(cmd_sel_o), DW'(0));
  endtask

  // called at a negedge; returns at a negedge after the last byte is taken
  task automatic send_txn(input int nbytes, input int rlen, input bit gap);
    for (int b = 0; b < nbytes; b++) begin
      req_valid   = 1'b1;
      req_data    = DW'($urandom);
      req_is_cmd  = (b == 0);
      req_rsp_len = (b == nbytes - 1) ? LW'(rlen) : '0;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      if (gap) begin
        req_valid = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  task automatic wait_idle();
    req_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state(); // R1 from power-up
    rst = 1'b0;
    @(negedge clk);
    check_reset_state(); // R1 idle after release

    send_txn(1, 0, 1'b1);          // R3 R5 single command byte
    wait_idle();
    send_txn(2, 0, 1'b1);          // R4 command then parameter
    wait_idle();
    send_txn(1, 1, 1'b1);          // R6 R7 one response byte
    wait_idle();
    send_txn(1, 2, 1'b1);          // R8 two response bytes with gap
    wait_idle();
    send_txn(4, 0, 1'b0);          // R9 valid held across bytes
    send_txn(3, 3, 1'b0);          // R9 next request pending during read
    send_txn(1, 15, 1'b0);         // R6 maximum response count
    send_txn(2, 1, 1'b0);
    wait_idle();
    for (int t = 0; t < 12; t++) begin
      send_txn($urandom_range(1, 4), $urandom_range(0, 4), 1'($urandom_range(0, 1)));
    end
    wait_idle();

    // R1 reset in the middle of a read
    send_txn(1, 2, 1'b0);
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();
    send_txn(2, 1, 1'b1);
    wait_idle();

    chk("R6", DW'(n_rsp > 40), DW'(1));
    finish_run();
  end

endmodule